// File: doc/BRIEF.md
# ADC Serial Output Data Port

This block is the output stage of a converter. When the digital filter finishes a conversion, it strobes a finished word into the port. The port lowers an active-low data-ready flag. It then waits for an external device to assert chip select, and after that it shifts the word out most significant bit first on a serial data line. The data line carries an output-enable so that the pad is high impedance whenever no word is moving.

A mode input chooses who owns the shift clock:

- **Self-clocking mode:** the port divides its master clock and drives the serial clock itself.
- **External-clocking mode:** a master drives the serial clock in. The port synchronizes that clock into the master domain and advances one bit on every falling edge it detects.

If nobody reads a word, data-ready goes back high two master clocks before the next word is due, so a reader never starts on stale data. A word that arrives during a transfer is parked until the transfer ends.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, data-ready (drdy_no) is high, the data output-enable (sdata_oe_o) is low and the generated serial clock (sclk_o) is low.
- R2: A load strobe makes drdy_no low on the following master clock cycle.
- R3: The word is sent most significant bit first, bit WORD_W-1 down to bit 0, with the MSB on the line as soon as the transfer begins.
- R4: With mode_i=1 (self-clocking), sclk_oe_o is high. sclk_o is low for the first SCLK_DIV/2 master cycles of each bit and high for the rest, so one transfer lasts exactly WORD_W*SCLK_DIV master cycles. sclk_o stays low while no transfer runs. With mode_i=0, sclk_oe_o and sclk_o are low.
- R5: With mode_i=0, the data line advances only on a falling edge of sclk_i. While sclk_i is held high, the bit does not change.
- R6: sdata_oe_o is high only while a transfer is in progress and goes low once bit 0 has been clocked out.
- R7: drdy_no returns high on the cycle the transfer finishes, unless a newer word is waiting.
- R8: If a word is never read, drdy_no rises exactly FRAME_CYCLES-2 master cycles after its load. That is two cycles before the next load, which is due FRAME_CYCLES cycles after the previous one.
- R9: A transfer begins only when cs_ni is low while data-ready is low. With cs_ni held high, sdata_oe_o stays low.
- R10: A word loaded during a transfer does not alter the bits of that transfer. When the transfer finishes, drdy_no stays low, and the next transfer sends the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle strobe: new word from the filter |
| word_i | input | WORD_W | Conversion word captured on load_i |
| cs_ni | input | 1 | Chip select, active low |
| mode_i | input | 1 | 1 = port drives the serial clock, 0 = serial clock is an input |
| sclk_i | input | 1 | External serial clock (mode_i=0) |
| sclk_o | output | 1 | Generated serial clock (mode_i=1) |
| sclk_oe_o | output | 1 | Enable for the serial clock pad driver |
| sdata_o | output | 1 | Serial data, MSB first |
| sdata_oe_o | output | 1 | Data pad enable; low means high impedance |
| drdy_no | output | 1 | Data ready, active low |

## Verification
A fixed set of bit patterns is shifted out in both clock modes: all zeros, all ones, the two alternating patterns, a lone MSB, a lone LSB, and arithmetic mixes. The alternating and single-bit words separate a correct MSB-first order from a reversed, shifted or stuck-bit order. Running the same words in both modes tells a fault in the clock divider apart from a fault in the external-edge path. Holding the external clock high mid-bit exposes an advance on the wrong edge. Separate sequences cover three more cases: a word that is never read, where the exact cycle of the data-ready timeout is checked; chip select held high; and a load injected mid-transfer, which must leave the running word intact and be sent next.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  typedef enum logic {
    MODE_EXT  = 1'b0,
    MODE_SELF = 1'b1
  } sclk_mode_e;
endpackage

// File: rtl/adc_sp_clkgen.sv
module adc_sp_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // low half first, so the receiver sees a rising edge mid-bit
  assign sclk_o = run_i && (cnt_q >= HALF);
  assign fall_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/adc_sp_sync.sv
module adc_sp_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= sclk_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall_o = s3_q && !s2_q;
endmodule

// File: rtl/adc_sp_shifter.sv
module adc_sp_shifter #(
  parameter int W     = 20,
  parameter int FRAME = 512
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         cs_ni,
  input  logic         shift_i,
  output logic         busy_o,
  output logic         sdata_o,
  output logic         drdy_no
);
  localparam int IW = $clog2(W);
  localparam int FW = $clog2(FRAME);
  localparam logic [FW-1:0] DROP_AT = FW'(FRAME - 3);
  localparam logic [IW-1:0] MSB_IDX = IW'(W - 1);

  logic [W-1:0]  word_q, pend_word_q;
  logic          pend_q, have_q, busy_q;
  logic [IW-1:0] idx_q;
  logic [FW-1:0] fcnt_q;
  logic          expired;

  assign expired = (fcnt_q == DROP_AT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            fcnt_q <= '0;
    else if (load_i)        fcnt_q <= '0;
    else if (!expired)      fcnt_q <= fcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q      <= '0;
      pend_word_q <= '0;
      pend_q      <= 1'b0;
      have_q      <= 1'b0;
      busy_q      <= 1'b0;
      idx_q       <= '0;
    end else if (busy_q) begin
      if (shift_i && idx_q == '0) begin
        busy_q <= 1'b0;
        pend_q <= 1'b0;
        have_q <= load_i || pend_q;
        if (load_i)      word_q <= word_i;
        else if (pend_q) word_q <= pend_word_q;
      end else begin
        if (load_i) begin
          pend_word_q <= word_i;
          pend_q      <= 1'b1;
        end
        if (shift_i) idx_q <= idx_q - 1'b1;
      end
    end else if (load_i) begin
      word_q <= word_i;
      have_q <= 1'b1;
    end else if (have_q && expired) begin
      have_q <= 1'b0;
    end else if (have_q && !cs_ni) begin
      busy_q <= 1'b1;
      idx_q  <= MSB_IDX;
    end
  end

  assign busy_o  = busy_q;
  assign sdata_o = word_q[idx_q];
  assign drdy_no = !have_q;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int WORD_W      = 20,
  parameter int SCLK_DIV    = 4,
  parameter int FRAME_CYCLES = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              cs_ni,
  input  logic              mode_i,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              drdy_no
);
  logic self_clk, busy, gen_sclk, gen_fall, ext_fall, shift_evt;

  assign self_clk = (sclk_mode_e'(mode_i) == MODE_SELF);

  adc_sp_clkgen #(.DIV(SCLK_DIV)) i_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy && self_clk),
    .sclk_o (gen_sclk),
    .fall_o (gen_fall)
  );

  adc_sp_sync i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .fall_o (ext_fall)
  );

  assign shift_evt = self_clk ? gen_fall : ext_fall;

  adc_sp_shifter #(.W(WORD_W), .FRAME(FRAME_CYCLES)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .word_i  (word_i),
    .cs_ni   (cs_ni),
    .shift_i (shift_evt),
    .busy_o  (busy),
    .sdata_o (sdata_o),
    .drdy_no (drdy_no)
  );

  assign sclk_o     = self_clk && gen_sclk;
  assign sclk_oe_o  = self_clk;
  assign sdata_oe_o = busy;
endmodule

// File: rtl/adc_sp_checker.sv
module adc_sp_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic load_i,
  input logic cs_ni,
  input logic sclk_o,
  input logic sdata_o,
  input logic sdata_oe_o,
  input logic drdy_no,
  input logic shift_evt
);
  assert_load_drdy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !drdy_no);

  assert_idle_sclk_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdata_oe_o |-> !sclk_o);

  assert_hold_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdata_oe_o && $past(sdata_oe_o) && !$past(shift_evt)) |-> $stable(sdata_o));

  assert_oe_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdata_oe_o |-> !drdy_no);

  assert_start_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdata_oe_o) |-> $past(!cs_ni));
endmodule

bind adc_serial_port adc_sp_checker i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .cs_ni      (cs_ni),
  .sclk_o     (sclk_o),
  .sdata_o    (sdata_o),
  .sdata_oe_o (sdata_oe_o),
  .drdy_no    (drdy_no),
  .shift_evt  (shift_evt)
);

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
  localparam int W     = 20;
  localparam int DIV   = 4;
  localparam int FRAME = 512;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic         cs_ni = 1'b1;
  logic         mode_i = 1'b1;
  logic         sclk_i = 1'b0;
  logic         sclk_o, sclk_oe_o, sdata_o, sdata_oe_o, drdy_no;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  adc_serial_port #(.WORD_W(W), .SCLK_DIV(DIV), .FRAME_CYCLES(FRAME)) i_adc_serial_port (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .word_i(word_i), .cs_ni(cs_ni),
    .mode_i(mode_i), .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o), .drdy_no(drdy_no)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_word(input logic [W-1:0] w, input bit check_drdy);
    @(negedge clk);
    load_i = 1'b1;
    word_i = w;
    @(negedge clk);
    load_i = 1'b0;
    if (check_drdy) chk("R2 drdy low after load", 32'(drdy_no), 32'd0);
  endtask

  // self-clocking read; optionally injects a new word mid-transfer
  task automatic ssc_read(input logic [W-1:0] exp, input bit inject,
                          input logic [W-1:0] nxt, input bit exp_drdy);
    logic [W-1:0] got = '0;
    int  oe_cyc = 0;
    int  rises  = 0;
    int  guard  = 0;
    bit  prev   = 1'b0;
    @(negedge clk);
    cs_ni = 1'b0;
    chk("R4 sclk_oe high in self mode", 32'(sclk_oe_o), 32'd1);
    do begin
      @(negedge clk);
      guard++;
      if (inject && guard == 30) begin load_i = 1'b1; word_i = nxt; end
      if (inject && guard == 31) load_i = 1'b0;
      if (sdata_oe_o) oe_cyc++;
      if (sclk_o && !prev) begin
        got = {got[W-2:0], sdata_o};
        rises++;
      end
      prev = sclk_o;
    end while ((oe_cyc == 0 || sdata_oe_o) && guard < 400);
    cs_ni = 1'b1;
    chk("R3 word MSB first (self)", 32'(got), 32'(exp));
    chk("R4 sclk rising edges", 32'(rises), 32'(W));
    chk("R4 transfer length W*DIV", 32'(oe_cyc), 32'(W * DIV));
    chk("R6 oe low after last bit", 32'(sdata_oe_o), 32'd0);
    chk("R7/R10 drdy after transfer", 32'(drdy_no), 32'(exp_drdy));
  endtask

  task automatic sec_read(input logic [W-1:0] exp);
    logic [W-1:0] got = '0;
    int  unstable = 0;
    bit  b;
    @(negedge clk);
    mode_i = 1'b0;
    cs_ni  = 1'b0;
    cyc(3);
    chk("R4 no clock drive in external mode", 32'({sclk_oe_o, sclk_o}), 32'd0);
    chk("R3 MSB present at start", 32'({sdata_oe_o, sdata_o}), 32'({1'b1, exp[W-1]}));
    for (int i = 0; i < W; i++) begin
      sclk_i = 1'b1;
      cyc(3);
      b = sdata_o;
      got = {got[W-2:0], b};
      cyc(4);
      if (sdata_o !== b) unstable++;
      sclk_i = 1'b0;
      cyc(6);
    end
    cs_ni = 1'b1;
    chk("R3 word MSB first (external)", 32'(got), 32'(exp));
    chk("R5 bit steady while sclk high", 32'(unstable), 32'd0);
    chk("R6 oe low after last fall", 32'(sdata_oe_o), 32'd0);
    chk("R7 drdy high after last bit", 32'(drdy_no), 32'd1);
    @(negedge clk);
    mode_i = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] pats[8];
    int oe_seen;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    chk("R1 reset drdy high", 32'(drdy_no), 32'd1);
    chk("R1 reset oe low", 32'(sdata_oe_o), 32'd0);
    chk("R1 reset sclk low", 32'(sclk_o), 32'd0);

    pats[0] = '0;
    pats[1] = '1;
    pats[2] = {(W/2){2'b10}};
    pats[3] = {(W/2){2'b01}};
    pats[4] = W'(1) << (W - 1);
    pats[5] = W'(1);
    for (int k = 6; k < 8; k++) pats[k] = W'((k * 32'h2F1D3) ^ (32'h9A5C7 >> k));

    for (int k = 0; k < 8; k++) begin
      load_word(pats[k], 1'b1);
      ssc_read(pats[k], 1'b0, '0, 1'b1);
      load_word(~pats[k], 1'b1);
      sec_read(~pats[k]);
    end

    // R9 + R8: no chip select, word expires FRAME-2 cycles after load
    load_word(W'(20'h3C5A1), 1'b1);
    oe_seen = 0;
    for (int k = 1; k <= FRAME - 3; k++) begin
      @(negedge clk);
      if (sdata_oe_o) oe_seen++;
    end
    chk("R9 no transfer without cs", 32'(oe_seen), 32'd0);
    chk("R8 drdy still low at FRAME-3", 32'(drdy_no), 32'd0);
    @(negedge clk);
    chk("R8 drdy high at FRAME-2", 32'(drdy_no), 32'd1);
    @(negedge clk);
    cs_ni = 1'b0;
    cyc(4);
    chk("R9 expired word not sent", 32'(sdata_oe_o), 32'd0);
    cs_ni = 1'b1;

    // R10: load during transfer is held and sent next
    load_word(W'(20'hB00D5), 1'b1);
    ssc_read(W'(20'hB00D5), 1'b1, W'(20'h4E2C7), 1'b0);
    ssc_read(W'(20'h4E2C7), 1'b0, '0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule